// File: doc/BRIEF.md
# SMBus Register Target with Chained Address Assignment

This block is an SMBus target that holds a small file of 8-bit configuration and status registers. It watches SCL and SDA, which are open-drain lines. Its only bus output pulls SDA low. It accepts two kinds of transaction. A single-byte write selects a register index and stores one data byte. A read selects an index, issues a repeated START with the read direction bit, and then shifts one byte out, MSB first.

The block's own 7-bit bus address is stored in register 0. After reset the address is 0x17, so the write byte is 0x2E and the read byte is 0x2F. Any write to register 0 loads a new address and drives the chain output high. That output goes to the reset input of the next identical device. A host can therefore give every device on a shared bus its own address in turn. Holding the chain reset input low restores every register default and pulls the chain output low.

SCL and SDA pass through a two-stage synchronizer on the system clock before any edge is decoded. Status bits and counter values come straight from input ports. The configuration registers are presented on a flat output bus. The block has no data stream that flows in or out, so none of its ports use a valid/ready handshake. Every pin is a plain level.

Top module: `smbt_chain_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal the current device address. After reset that address is 0x17. On any other address the target leaves SDA released for the remainder of the transaction.
- R2: A write runs as START, address byte with bit 0 = 0, register index byte, data byte, STOP. The target acknowledges each of the three bytes. The data byte is then stored in the indexed writable register.
- R3: A read runs as START, address with bit 0 = 0, index, repeated START, address with bit 0 = 1. The target then drives the indexed register MSB first and releases SDA after the eighth bit, ignoring the host's acknowledge bit.
- R4: Register indices 0x00 to 0x0B are acknowledged. Any larger index is not acknowledged, and the data byte that follows changes no register.
- R5: A write to register 0 stores data bits 7:1 as the new device address. Bit 0 always reads back as 0. From then on only the new address is acknowledged.
- R6: Any write to register 0 drives the chain output high. It stays high until the chain reset input goes low.
- R7: While the chain reset input is low, every register returns to its default, the chain output is low and SDA is released. Afterwards the address is again 0x17.
- R8: Registers 1, 9, 0x0A and 0x0B are read-only, and writes to them are ignored. Register 1 reads as {5'b0, complement-leg fault, true-leg fault, loss of signal}, from bit 7 down to bit 0. Register 9 reads 0x13, which is a revision field 10b in bits 4:3 and a part field 011b in bits 2:0. Registers 0x0A and 0x0B read the true-leg and complement-leg 5-bit counter inputs, with bits 7:5 as zero.
- R9: The reset defaults are: register 0 = 0x2E, register 3 = 0xC0, register 4 = 0x90 (amplitude field 4:0 = 10000b, threshold field 7:5 = 100b), register 5 = 0x02. Every other writable register resets to 0x00.
- R10: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP before the data byte ends the transaction with no register change. The target only begins pulling SDA low while SCL is low.
- R11: Output cfg_o byte k (bits 8k+7:8k) always equals register k+2, for k = 0 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Chain reset input, active low, asynchronous; restores defaults |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_lo_o | output | 1 | High to pull SDA low (open-drain drive) |
| chain_rst_o | output | 1 | Chain output to the next device's reset input |
| los_i | input | 1 | Loss-of-signal status bit |
| tf_pos_i | input | 1 | True-leg termination fault status |
| tf_neg_i | input | 1 | Complement-leg termination fault status |
| tf_pos_cnt_i | input | 5 | True-leg fault counter value |
| tf_neg_cnt_i | input | 5 | Complement-leg fault counter value |
| cfg_o | output | 56 | Registers 2 to 8, byte k holding register k+2 |

## Verification
The assertions assume the following about the bus and the status inputs:
- Each SCL high phase and each SCL low phase lasts several system clocks, so the synchronizer never misses an edge and the target's drive change falls inside the low phase.
- SDA changes while SCL is high only to form a START or a STOP.
- The status and counter inputs are synchronous to clk.

The bench's bit-bang host keeps to these assumptions. It uses quarter-bit phases of ten clocks, changes SDA only a full quarter after SCL has fallen, and changes the status inputs only while the bus is idle.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_HOLD
  } smbt_state_e;

  localparam logic [7:0] SMBT_VERSION = 8'h13;

  // Writable locations: 0 and 2..8
  function automatic logic smbt_is_rw(input int unsigned idx);
    return (idx == 0) || (idx >= 2 && idx <= 8);
  endfunction

  function automatic logic [7:0] smbt_reset_value(input int unsigned idx,
                                                  input logic [6:0] addr);
    case (idx)
      0:       return {addr, 1'b0};
      3:       return 8'hC0;
      4:       return 8'h90;
      5:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       scl,
  input  logic       sda,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start,
  input  logic       stop,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_lo
);
  localparam logic [7:0] IDX_LIMIT = 8'(NUM_REGS);

  smbt_state_e state;
  logic [7:0]  shift;
  logic [3:0]  cnt;
  logic        rw;
  logic [7:0]  idx_q;

  assign rd_idx = idx_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      shift   <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      idx_q   <= '0;
      sda_lo  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop) begin
        state  <= ST_IDLE;
        sda_lo <= 1'b0;
      end else if (start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_lo <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INDEX, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              shift <= {shift[6:0], sda};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shift[7:1] == dev_addr) begin
                  rw     <= shift[0];
                  sda_lo <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_INDEX) begin
                if (shift < IDX_LIMIT) begin
                  idx_q  <= shift;
                  sda_lo <= 1'b1;
                  state  <= ST_INDEX_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= idx_q;
                wr_data <= shift;
                sda_lo  <= 1'b1;
                state   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shift  <= rd_data;
                sda_lo <= ~rd_data[7];
                state  <= ST_RDATA;
              end else begin
                sda_lo <= 1'b0;
                state  <= ST_INDEX;
              end
            end
          end
          ST_INDEX_ACK: begin
            if (scl_fall) begin
              sda_lo <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_lo <= 1'b0;
              state  <= ST_HOLD;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_lo <= 1'b0;
                state  <= ST_HOLD;
              end else begin
                cnt    <= cnt + 4'd1;
                shift  <= {shift[6:0], 1'b0};
                sda_lo <= ~shift[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(state) == ST_ADDR && state == ST_ADDR_ACK) |-> $past(shift[7:1] == dev_addr)); // R1
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> (wr_idx < IDX_LIMIT)); // R4
  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sda_lo) |-> !scl); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_ni)
    stop |=> !sda_lo); // R10

endmodule

// File: rtl/smbt_regs.sv
module smbt_regs
  import smbt_pkg::*;
#(
  parameter int         NUM_REGS = 12,
  parameter logic [6:0] DEF_ADDR = 7'h17,
  parameter int         CFG_REGS = 7
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  input  logic                  los_i,
  input  logic                  tf_pos_i,
  input  logic                  tf_neg_i,
  input  logic [4:0]            tf_pos_cnt_i,
  input  logic [4:0]            tf_neg_cnt_i,
  output logic [7:0]            rd_data,
  output logic [6:0]            dev_addr,
  output logic                  chain_o,
  output logic [8*CFG_REGS-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [7:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (smbt_is_rw(i)) begin : g_rw
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)
          regs_q[i] <= smbt_reset_value(i, DEF_ADDR);
        else if (wr_en && wr_idx == 8'(i))
          regs_q[i] <= (i == 0) ? {wr_data[7:1], 1'b0} : wr_data;
      end
    end else begin : g_ro
      assign regs_q[i] = 8'h00;
    end
  end

  for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
    assign cfg_o[8*k +: 8] = regs_q[k+2];
  end

  assign dev_addr = regs_q[0][7:1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      chain_o <= 1'b0;
    else if (wr_en && wr_idx == 8'd0)
      chain_o <= 1'b1;
  end

  always_comb begin
    case (rd_idx)
      8'h01:   rd_data = {5'b0, tf_neg_i, tf_pos_i, los_i};
      8'h09:   rd_data = SMBT_VERSION;
      8'h0A:   rd_data = {3'b0, tf_pos_cnt_i};
      8'h0B:   rd_data = {3'b0, tf_neg_cnt_i};
      default: rd_data = (rd_idx < 8'(NUM_REGS)) ? regs_q[rd_idx[IDX_W-1:0]] : 8'h00;
    endcase
  end

  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    chain_o |=> chain_o); // R6
  AST_CHAIN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_idx == 8'd0) |=> chain_o); // R6
  AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_idx == 8'd0) |=> dev_addr == $past(wr_data[7:1])); // R5

endmodule

// File: rtl/smbt_chain_target.sv
module smbt_chain_target #(
  parameter logic [6:0] DEF_ADDR    = 7'h17,
  parameter int         NUM_REGS    = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_lo_o,
  output logic        chain_rst_o,
  input  logic        los_i,
  input  logic        tf_pos_i,
  input  logic        tf_neg_i,
  input  logic [4:0]  tf_pos_cnt_i,
  input  logic [4:0]  tf_neg_cnt_i,
  output logic [55:0] cfg_o
);
  localparam int CFG_REGS = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [6:0] dev_addr;
  logic [7:0] rd_data, rd_idx, wr_idx, wr_data;
  logic       wr_en;

  smbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smbt_engine #(.NUM_REGS(NUM_REGS)) u_engine (
    .clk(clk), .rst_ni(rst_ni), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
    .dev_addr(dev_addr), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_lo(sda_lo_o)
  );

  smbt_regs #(.NUM_REGS(NUM_REGS), .DEF_ADDR(DEF_ADDR), .CFG_REGS(CFG_REGS)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .los_i(los_i), .tf_pos_i(tf_pos_i), .tf_neg_i(tf_neg_i),
    .tf_pos_cnt_i(tf_pos_cnt_i), .tf_neg_cnt_i(tf_neg_cnt_i),
    .rd_data(rd_data), .dev_addr(dev_addr), .chain_o(chain_rst_o), .cfg_o(cfg_o)
  );

endmodule

// File: tb/tb_smbt_chain_target.sv
module tb_smbt_chain_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic sda_lo, chain;
  logic los = 1'b0, tfp = 1'b0, tfn = 1'b0;
  logic [4:0] cp = 5'd0, cn = 5'd0;
  logic [55:0] cfg;
  logic sda_bus;
  assign sda_bus = host_sda & ~sda_lo;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  smbt_chain_target dut (
    .clk(clk), .rst_ni(rst_ni), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_lo_o(sda_lo), .chain_rst_o(chain), .los_i(los), .tf_pos_i(tfp),
    .tf_neg_i(tfn), .tf_pos_cnt_i(cp), .tf_neg_cnt_i(cn), .cfg_o(cfg)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(Q);
      host_scl = 1'b1; tick(2*Q);
      host_scl = 1'b0; tick(Q);
    end
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      host_scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      host_scl = 1'b0; tick(Q);
    end
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(2*Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                           output bit a1, output bit a2, output bit a3);
    bus_start();
    send_byte({a, 1'b0}, a1);
    send_byte(idx, a2);
    send_byte(d, a3);
    bus_stop();
    tick(Q);
  endtask

  task automatic read_reg(input logic [6:0] a, input logic [7:0] idx, output logic [7:0] d,
                          output bit a1, output bit a2, output bit a3);
    bus_start();
    send_byte({a, 1'b0}, a1);
    send_byte(idx, a2);
    bus_start();
    send_byte({a, 1'b1}, a3);
    recv_byte(d);
    bus_stop();
    tick(Q);
  endtask

  task automatic t_reset_state();
    logic [7:0] d; bit a1, a2, a3;
    chk("R7 chain low after reset", chain, 0);
    chk("R7 sda released after reset", sda_lo, 0);
    chk("R9 R11 reg2 default", cfg[7:0], 8'h00);
    chk("R9 R11 reg3 default", cfg[15:8], 8'hC0);
    chk("R9 R11 reg4 default", cfg[23:16], 8'h90);
    chk("R9 R11 reg5 default", cfg[31:24], 8'h02);
    read_reg(7'h17, 8'h00, d, a1, a2, a3);
    chk("R1 default address acked", {a1, a2, a3}, 3'b111);
    chk("R3 R9 reg0 default readback", d, 8'h2E);
    read_reg(7'h17, 8'h04, d, a1, a2, a3);
    chk("R3 R9 reg4 readback", d, 8'h90);
  endtask

  task automatic t_wrong_address();
    bit a1, a2, a3;
    write_reg(7'h20, 8'h02, 8'h5A, a1, a2, a3);
    chk("R1 foreign address nacked", {a1, a2, a3}, 3'b000);
    chk("R1 foreign write no effect", cfg[7:0], 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d; bit a1, a2, a3;
    write_reg(7'h17, 8'h02, 8'hA5, a1, a2, a3);
    chk("R2 write acks", {a1, a2, a3}, 3'b111);
    chk("R2 R11 reg2 written", cfg[7:0], 8'hA5);
    read_reg(7'h17, 8'h02, d, a1, a2, a3);
    chk("R3 read acks", {a1, a2, a3}, 3'b111);
    chk("R3 reg2 readback", d, 8'hA5);
    chk("R3 sda released after read", sda_lo, 0);
    write_reg(7'h17, 8'h08, 8'h3C, a1, a2, a3);
    chk("R11 reg8 on cfg", cfg[55:48], 8'h3C);
    read_reg(7'h17, 8'h08, d, a1, a2, a3);
    chk("R3 reg8 readback", d, 8'h3C);
  endtask

  task automatic t_index_range();
    logic [7:0] d; bit a1, a2, a3;
    write_reg(7'h17, 8'h0C, 8'hFF, a1, a2, a3);
    chk("R4 index 0x0C nacked", {a1, a2, a3}, 3'b100);
    chk("R4 no register changed", cfg, {8'h3C, 8'h00, 8'h00, 8'h02, 8'h90, 8'hC0, 8'hA5});
    read_reg(7'h17, 8'h0B, d, a1, a2, a3);
    chk("R4 index 0x0B acked", {a1, a2, a3}, 3'b111);
  endtask

  task automatic t_read_only();
    logic [7:0] d; bit a1, a2, a3;
    los = 1'b1; tfp = 1'b0; tfn = 1'b1; cp = 5'h1A; cn = 5'h07;
    tick(2);
    read_reg(7'h17, 8'h01, d, a1, a2, a3);
    chk("R8 status bits", d, 8'h05);
    write_reg(7'h17, 8'h01, 8'hFF, a1, a2, a3);
    los = 1'b0; tfp = 1'b1; tfn = 1'b0;
    tick(2);
    read_reg(7'h17, 8'h01, d, a1, a2, a3);
    chk("R8 status follows inputs after write", d, 8'h02);
    write_reg(7'h17, 8'h09, 8'h00, a1, a2, a3);
    read_reg(7'h17, 8'h09, d, a1, a2, a3);
    chk("R8 version ignores write", d, 8'h13);
    read_reg(7'h17, 8'h0A, d, a1, a2, a3);
    chk("R8 true-leg counter", d, 8'h1A);
    read_reg(7'h17, 8'h0B, d, a1, a2, a3);
    chk("R8 complement-leg counter", d, 8'h07);
  endtask

  task automatic t_abort();
    bit a1, a2;
    bus_start();
    send_byte({7'h17, 1'b0}, a1);
    send_byte(8'h03, a2);
    bus_stop();
    tick(Q);
    chk("R10 STOP before data acks", {a1, a2}, 2'b11);
    chk("R10 STOP before data no write", cfg[15:8], 8'hC0);
  endtask

  task automatic t_chain();
    logic [7:0] d; bit a1, a2, a3;
    chk("R6 chain low before reg0 write", chain, 0);
    write_reg(7'h17, 8'h00, 8'h59, a1, a2, a3);
    chk("R6 chain high after reg0 write", chain, 1);
    read_reg(7'h17, 8'h00, d, a1, a2, a3);
    chk("R5 old address nacked", a1, 0);
    read_reg(7'h2C, 8'h00, d, a1, a2, a3);
    chk("R5 new address acked", {a1, a2, a3}, 3'b111);
    chk("R5 reg0 bit0 reads zero", d, 8'h58);
    write_reg(7'h2C, 8'h02, 8'h77, a1, a2, a3);
    chk("R5 write via new address", cfg[7:0], 8'h77);
    chk("R6 chain stays high", chain, 1);
  endtask

  task automatic t_reset_in();
    logic [7:0] d; bit a1, a2, a3;
    rst_ni = 1'b0;
    tick(3);
    chk("R7 chain low in reset", chain, 0);
    chk("R7 cfg defaults in reset", cfg, {8'h00, 8'h00, 8'h00, 8'h02, 8'h90, 8'hC0, 8'h00});
    rst_ni = 1'b1;
    tick(3);
    read_reg(7'h17, 8'h00, d, a1, a2, a3);
    chk("R7 default address restored", {a1, a2, a3}, 3'b111);
    chk("R7 reg0 default restored", d, 8'h2E);
  endtask

  initial begin
    tick(5);
    rst_ni = 1'b1;
    tick(5);
    t_reset_state();
    t_wrong_address();
    t_write_read();
    t_index_range();
    t_read_only();
    t_abort();
    t_chain();
    t_reset_in();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule